// File: doc/BRIEF.md
# Half-Duty Vacuum Fluorescent Display Multiplexer

This block time-shares one bank of segment drive lines between two grid electrodes of a vacuum fluorescent display. A frame of 4096 clock periods is split into two equal slots of 2048 clocks. In the first slot grid A is lit and the 41 segment lines carry the lower half of the display word. In the second slot grid B is lit and the segment lines carry the upper half. The display word holds 82 bits, so 82 segments can be addressed. Each segment bit drives its line directly, with no character decoder in between.

A host-side parser supplies the 82-bit display word, a 2-bit dimming code and a sleep flag. New display words are taken in only at a frame boundary, so a half-written update never reaches the glass. An active-high blank input acts as the block's reset and forces every output dark at once. Each slot opens with four guard clocks in which no grid is lit, so the two grids never overlap. The dimming code cuts the lit part of each slot short.

A state register tracks the phase. ST_IDLE holds while blank is high. ST_SLEEP holds while sleep is high. In running mode each slot steps through ST_GAP_A, ST_LIT_A, ST_DIM_A or ST_GAP_B, ST_LIT_B, ST_DIM_B. The transitions are:
- blank-assert, from any state to ST_IDLE.
- sleep-enter, from any running state to ST_SLEEP.
- wake, from ST_IDLE or ST_SLEEP to ST_GAP_A.
- guard-done, from gap to lit.
- dim-cut, from lit to dim.
- slot-change, from lit or dim of A to ST_GAP_B.
- frame-wrap, from lit or dim of B to ST_GAP_A.

Top module: `vfd_half_duty_mux`

## Requirements
- R1: While blank is 1, grid_en and seg_en are all zero in the same cycle, whatever disp_data holds. Blank also restarts the frame.
- R2: One frame lasts 4096 clocks. Grid A goes high at the 4th rising edge that samples blank and sleep both low, and again 4096 edges later.
- R3: Grid A (grid_en = 2'b01) is lit at frame positions 4 up to the dim limit. While it is lit, seg_en[i] equals bit i of the latched word, for i = 0..40.
- R4: Grid B (grid_en = 2'b10) is lit at frame positions 2052 up to 2048 plus the dim limit. While it is lit, seg_en[i] equals bit 41+i of the latched word.
- R5: The two grids are never lit together. Each grid turn-on follows at least one cycle with both grids off: 4 guard cycles at dim code 0.
- R6: With dim code d, each slot's lit window ends at slot position 512*(4-d). That gives 2044, 1532, 1020 or 508 lit clocks for d = 0, 1, 2, 3. While no grid is lit, seg_en is zero.
- R7: One edge after sleep is sampled high, all outputs are zero, and they stay zero while sleep is held. After wake, the frame restarts as in R2.
- R8: A change on disp_data in mid-frame leaves seg_en unchanged until the next frame. The new word shows from the next grid A window. While blank or sleep is high, the word is loaded on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| blank | input | 1 | Active-high blank and reset |
| sleep | input | 1 | Sleep request; stops the frame |
| dim | input | 2 | Dimming code, 0 brightest |
| disp_data | input | 82 | Display word; [40:0] grid A, [81:41] grid B |
| grid_en | output | 2 | Grid enables; bit 0 grid A, bit 1 grid B |
| seg_en | output | 41 | Segment enables for the lit grid |

## Verification
Grid and segment timing is counted in edges after the first edge that sees blank and sleep both low. That edge brings the frame counter to position 1, so a grid change at frame position p is due just after edge p. The bench keeps its own edge count and samples 5 ns after each edge at exactly those positions, checking both sides of every boundary. Blank acts combinationally, so it is checked 1 ns after it is driven. Sleep is sampled, so it is checked one edge later. A mid-frame data change is checked on the next edge, at the end of the old frame, and at the first grid A window of the new frame.

// File: rtl/vfd_mux_pkg.sv
`timescale 1ns/1ps
package vfd_mux_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLEEP,
        ST_GAP_A,
        ST_LIT_A,
        ST_DIM_A,
        ST_GAP_B,
        ST_LIT_B,
        ST_DIM_B
    } vfd_phase_e;
endpackage

// File: rtl/vfd_frame_timer.sv
`timescale 1ns/1ps
module vfd_frame_timer #(
    parameter int FRAME_LEN = 4096,
    localparam int CNT_W = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] nxt,
    output logic             wrap
);
    // Frame position; held at zero while cleared (blank or sleep).
    always_comb begin
        wrap = (cnt == CNT_W'(FRAME_LEN - 1));
        if (clear || wrap) nxt = '0;
        else               nxt = cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        cnt <= nxt;
    end
endmodule

// File: rtl/vfd_frame_latch.sv
`timescale 1ns/1ps
module vfd_frame_latch #(
    parameter int N_SEG  = 41,
    parameter int N_GRID = 2
) (
    input  logic                          clk,
    input  logic                          load,
    input  logic [N_GRID*N_SEG-1:0]       d,
    output logic [N_GRID-1:0][N_SEG-1:0]  bank
);
    // One shadow bank per grid, updated together at frame boundaries.
    for (genvar g = 0; g < N_GRID; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (load) bank[g] <= d[g*N_SEG +: N_SEG];
        end
    end
endmodule

// File: rtl/vfd_half_duty_mux.sv
`timescale 1ns/1ps
module vfd_half_duty_mux
    import vfd_mux_pkg::*;
#(
    parameter int N_SEG     = 41,
    parameter int FRAME_LEN = 4096,
    parameter int GUARD     = 4,
    parameter int DIM_W     = 2
) (
    input  logic                 clk,
    input  logic                 blank,
    input  logic                 sleep,
    input  logic [DIM_W-1:0]     dim,
    input  logic [2*N_SEG-1:0]   disp_data,
    output logic [1:0]           grid_en,
    output logic [N_SEG-1:0]     seg_en
);
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam int POS_W     = CNT_W - 1;
    localparam int LW        = CNT_W + 1;
    localparam int SLOT_LEN  = FRAME_LEN / 2;
    localparam int DIM_STEPS = 1 << DIM_W;
    localparam int STEP_LEN  = SLOT_LEN / DIM_STEPS;

    logic [CNT_W-1:0]       cnt;
    logic [CNT_W-1:0]       nxt;
    logic                   wrap;
    logic                   halt;
    logic [1:0][N_SEG-1:0]  bank;
    logic                   nxt_slot;
    logic [POS_W-1:0]       nxt_pos;
    logic [LW-1:0]          lit_end;
    vfd_phase_e             state, state_d;

    assign halt = blank | sleep;

    vfd_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
        .clk   (clk),
        .clear (halt),
        .cnt   (cnt),
        .nxt   (nxt),
        .wrap  (wrap)
    );

    vfd_frame_latch #(.N_SEG(N_SEG), .N_GRID(2)) u_latch (
        .clk  (clk),
        .load (halt | wrap),
        .d    (disp_data),
        .bank (bank)
    );

    // Next phase is decoded from the position the counter moves to.
    always_comb begin
        nxt_slot = nxt[CNT_W-1];
        nxt_pos  = nxt[POS_W-1:0];
        lit_end  = LW'(STEP_LEN) * (LW'(DIM_STEPS) - LW'(dim));
        if (blank) begin
            state_d = ST_IDLE;
        end else if (sleep) begin
            state_d = ST_SLEEP;
        end else if (LW'(nxt_pos) < LW'(GUARD)) begin
            state_d = nxt_slot ? ST_GAP_B : ST_GAP_A;
        end else if (LW'(nxt_pos) < lit_end) begin
            state_d = nxt_slot ? ST_LIT_B : ST_LIT_A;
        end else begin
            state_d = nxt_slot ? ST_DIM_B : ST_DIM_A;
        end
    end

    always_ff @(posedge clk) begin
        state <= state_d;
    end

    // Outputs follow the phase; blank darkens them without waiting a clock.
    always_comb begin
        grid_en = 2'b00;
        seg_en  = '0;
        unique case (state)
            ST_LIT_A: begin
                grid_en = 2'b01;
                seg_en  = bank[0];
            end
            ST_LIT_B: begin
                grid_en = 2'b10;
                seg_en  = bank[1];
            end
            ST_IDLE, ST_SLEEP, ST_GAP_A, ST_DIM_A, ST_GAP_B, ST_DIM_B: begin
                grid_en = 2'b00;
                seg_en  = '0;
            end
            default: begin
                grid_en = 2'b00;
                seg_en  = '0;
            end
        endcase
        if (blank) begin
            grid_en = 2'b00;
            seg_en  = '0;
        end
    end
endmodule

// File: rtl/vfd_mux_checker.sv
`timescale 1ns/1ps
module vfd_mux_checker #(
    parameter int N_SEG = 41
) (
    input logic             clk,
    input logic             blank,
    input logic             sleep,
    input logic [1:0]       grid_en,
    input logic [N_SEG-1:0] seg_en
);
    // R1: blank forces every output dark
    a_r1_blank_dark: assert property (@(posedge clk)
        blank |-> (grid_en == 2'b00 && seg_en == '0));

    // R5: grid B turns on only after a cycle with grid A off
    a_r5_gap_before_b: assert property (@(posedge clk) disable iff (blank)
        $rose(grid_en[1]) |-> $past(grid_en[0] == 1'b0));

    // R5: grid A turns on only after a cycle with grid B off
    a_r5_gap_before_a: assert property (@(posedge clk) disable iff (blank)
        $rose(grid_en[0]) |-> $past(grid_en[1] == 1'b0));

    // R6: no segment drive while no grid is lit
    a_r6_dark_segments: assert property (@(posedge clk) disable iff (blank)
        (grid_en == 2'b00) |-> (seg_en == '0));

    // R7: held sleep keeps all outputs off
    a_r7_sleep_dark: assert property (@(posedge clk) disable iff (blank)
        ($past(sleep) && sleep) |-> (grid_en == 2'b00 && seg_en == '0));

    // R8: segments do not move within a lit grid A window
    a_r8_stable_window: assert property (@(posedge clk) disable iff (blank)
        (grid_en[0] && $past(grid_en[0])) |-> $stable(seg_en));
endmodule

bind vfd_half_duty_mux vfd_mux_checker #(.N_SEG(N_SEG)) u_chk (
    .clk     (clk),
    .blank   (blank),
    .sleep   (sleep),
    .grid_en (grid_en),
    .seg_en  (seg_en)
);

// File: tb/vfd_half_duty_mux_tb.sv
`timescale 1ns/1ps
module vfd_half_duty_mux_tb;
    logic        clk = 1'b0;
    logic        blank = 1'b1;
    logic        sleep = 1'b0;
    logic [1:0]  dim = 2'd0;
    logic [81:0] disp_data = '0;
    logic [1:0]  grid_en;
    logic [40:0] seg_en;

    int total = 0;
    int bad   = 0;
    int t     = 0;
    bit done  = 1'b0;

    localparam logic [81:0] D1 = 82'h2_A5A5_1234_5678_9ABC_DEF0;
    localparam logic [81:0] D2 = 82'h1_5A3C_C3F0_0F96_6901_7E81;

    always #10 clk = ~clk;

    vfd_half_duty_mux u_dut (
        .clk       (clk),
        .blank     (blank),
        .sleep     (sleep),
        .dim       (dim),
        .disp_data (disp_data),
        .grid_en   (grid_en),
        .seg_en    (seg_en)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #5;
        t = t + n;
    endtask

    task automatic go_to(input int target);
        tick(target - t);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [81:0] act, input logic [81:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s at t=%0d: actual=%h expected=%h", req, what, t, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic [1:0] g, input logic [40:0] s);
        chk(grid_en == g, req, "grid_en", 82'(grid_en), 82'(g));
        chk(seg_en == s, req, "seg_en", 82'(seg_en), 82'(s));
    endtask

    // Blank pulse, then release; t counts edges after release.
    task automatic restart();
        blank = 1'b1;
        tick(2);
        blank = 1'b0;
        t = 0;
    endtask

    task automatic t_reset();
        disp_data = D1;
        tick(3);
        chk_out("R1", 2'b00, '0);
    endtask

    task automatic t_frame();
        dim = 2'd0;
        disp_data = D1;
        restart();
        go_to(3);    chk_out("R2", 2'b00, '0);
        go_to(4);    chk_out("R3", 2'b01, D1[40:0]);
        go_to(2047); chk_out("R3", 2'b01, D1[40:0]);
        go_to(2048); chk_out("R5", 2'b00, '0);
        go_to(2051); chk_out("R5", 2'b00, '0);
        go_to(2052); chk_out("R4", 2'b10, D1[81:41]);
        go_to(4095); chk_out("R4", 2'b10, D1[81:41]);
        go_to(4096); chk_out("R5", 2'b00, '0);
        go_to(4099); chk_out("R2", 2'b00, '0);
        go_to(4100); chk_out("R2", 2'b01, D1[40:0]);
    endtask

    task automatic t_dim();
        for (int d = 1; d < 4; d++) begin
            int lim;
            lim = 512 * (4 - d);
            dim = 2'(d);
            disp_data = D2;
            restart();
            go_to(4);              chk_out("R6", 2'b01, D2[40:0]);
            go_to(lim - 1);        chk_out("R6", 2'b01, D2[40:0]);
            go_to(lim);            chk_out("R6", 2'b00, '0);
            go_to(2052);           chk_out("R6", 2'b10, D2[81:41]);
            go_to(2048 + lim - 1); chk_out("R6", 2'b10, D2[81:41]);
            go_to(2048 + lim);     chk_out("R6", 2'b00, '0);
        end
        dim = 2'd0;
    endtask

    task automatic t_latch();
        dim = 2'd0;
        disp_data = D1;
        restart();
        go_to(100);
        disp_data = D2;
        go_to(101);  chk_out("R8", 2'b01, D1[40:0]);
        go_to(2052); chk_out("R8", 2'b10, D1[81:41]);
        go_to(4095); chk_out("R8", 2'b10, D1[81:41]);
        go_to(4100); chk_out("R8", 2'b01, D2[40:0]);
        go_to(6148); chk_out("R8", 2'b10, D2[81:41]);
    endtask

    task automatic t_sleep();
        dim = 2'd0;
        disp_data = D1;
        restart();
        go_to(1000); chk_out("R3", 2'b01, D1[40:0]);
        sleep = 1'b1;
        disp_data = D2;
        tick(1);    chk_out("R7", 2'b00, '0);
        tick(5000); chk_out("R7", 2'b00, '0);
        sleep = 1'b0;
        t = 0;
        go_to(3); chk_out("R7", 2'b00, '0);
        go_to(4); chk_out("R7", 2'b01, D2[40:0]);
    endtask

    task automatic t_blank();
        dim = 2'd0;
        disp_data = D1;
        restart();
        go_to(2100); chk_out("R4", 2'b10, D1[81:41]);
        blank = 1'b1;
        disp_data = D2;
        #1;
        chk_out("R1", 2'b00, '0);
        tick(10);
        chk_out("R1", 2'b00, '0);
        blank = 1'b0;
        t = 0;
        go_to(3); chk_out("R1", 2'b00, '0);
        go_to(4); chk_out("R1", 2'b01, D2[40:0]);
    endtask

    initial begin
        t_reset();
        t_frame();
        t_dim();
        t_latch();
        t_sleep();
        t_blank();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule